// File: doc/BRIEF.md
# Bus Error Cause Aggregator

This block gathers error reports from up to eight communication subunits into one cause word. Each subunit reports a fault with a one-cycle pulse, a three-bit kind (address miss, access-protection violation, write-protection violation) and the address of the failing access. Every subunit owns a four-bit group in the cause word. Two group slots are reserved and never take a report.

A mask word chooses which cause bits may raise the single level-sensitive interrupt. A capture register keeps the address of the first error that arrives while no unmasked cause is pending. Software reaches the three registers through a plain select/write/read port. It clears causes by writing zeros over them. The usual service sequence is to read the cause word and write back its inverse, which clears exactly the bits that were seen.

Top module: `err_cause_agg`

## Requirements
- R1: After a synchronous active-low reset, the cause word, the mask word and the captured address all read zero, and `irq` is low.
- R2: A pulse on `err_pulse[u]` ORs `err_kind[3u+2:3u]` into cause bits `4u+2:4u` on the next clock edge. Kind bit 0 is address miss, bit 1 is access protection and bit 2 is write protection. Bit `4u+3` never sets. Earlier bits stay set.
- R3: Reports from units 3 and 6 (the reserved slots) never set any cause bit and never load the captured address.
- R4: A write with `reg_sel`=0 clears every cause bit written as 0 and leaves every bit written as 1 unchanged.
- R5: `irq` is high exactly while some bit is set in both the cause word and the mask word. It rises right after the edge that sets such a bit and falls right after the edge that clears the last one.
- R6: When an error sets a cause bit in the same cycle as a write that clears that bit, the bit ends up set.
- R7: The captured address loads on an error only when no unmasked cause bit is pending before that edge. While one is pending, it holds the first address.
- R8: When several non-reserved units report in the same cycle, the lowest-numbered unit's address is the one captured.
- R9: `reg_sel`=1 writes and reads the mask. Only bits 0 to 2 of non-reserved groups are stored, so writing all ones reads back 0x70770777. `reg_sel`=2 reads the captured address, and writes to it have no effect. `reg_sel`=3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_pulse | input | NUM_UNITS | One-cycle error report, one bit per subunit |
| err_kind | input | NUM_UNITS*3 | Error kind per subunit, bit 0 miss, 1 access, 2 write |
| err_addr | input | NUM_UNITS*ADDR_W | Failing address per subunit |
| reg_sel | input | 2 | Register select: 0 cause, 1 mask, 2 address, 3 none |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | NUM_UNITS*4 | Write data |
| reg_rdata | output | NUM_UNITS*4 | Read data of the selected register |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a clearing write and a new report landing on the same bit, or on bits of the same group, in one cycle. The bench reaches it by driving the write strobe and the error pulse together from one negative edge. It then checks that the new bit survives while the old one is cleared. Keeping the first address also needs a specific order: an unmasked cause must be left pending while a second unit reports. After that, the pending bits are cleared and a third report must load again.

// File: rtl/err_cause_pkg.sv
// Package: shared constants and the register select encoding.
// Assumes a cause group is four bits wide, with three kind bits in use.
package err_cause_pkg;
    localparam int GROUP_W = 4;
    localparam int KIND_W  = 3;

    typedef enum logic [1:0] {
        SEL_CAUSE = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_ADDR  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/err_cause_group.sv
// Module: holds the live kind bits of one subunit's cause group.
// Assumes clr_we is a single-cycle write strobe. A set in the same cycle
// as a clear wins. The top bit of the group is tied to zero.
module err_cause_group
    import err_cause_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [KIND_W-1:0] kind,
    input  logic              clr_we,
    input  logic [KIND_W-1:0] keep_bits,
    output logic [GROUP_W-1:0] grp_q
);
    logic [KIND_W-1:0] bits_q;
    logic [KIND_W-1:0] kept;
    logic [KIND_W-1:0] set_v;

    // Bits that survive a clearing write this cycle.
    always_comb kept = clr_we ? (bits_q & keep_bits) : bits_q;

    // Bits the incoming report raises.
    always_comb set_v = evt ? kind : '0;

    // Cause state: report set takes priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= kept | set_v;
    end

    assign grp_q = {{(GROUP_W-KIND_W){1'b0}}, bits_q};
endmodule

// File: rtl/err_mask_reg.sv
// Module: mask register that stores only the implemented bits.
// Assumes IMPL marks the bits that can ever be set in the cause word.
module err_mask_reg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);
    // Mask state: loads on write, with unimplemented bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)  mask_q <= '0;
        else if (we) mask_q <= wdata & IMPL;
    end
endmodule

// File: rtl/err_addr_capture.sv
// Module: keeps the address of the first error taken while nothing
// unmasked is pending. The lowest-numbered valid unit wins a tie.
// Assumes valid already excludes reserved slots and empty kinds.
module err_addr_capture #(
    parameter int NUM_UNITS = 8,
    parameter int ADDR_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_UNITS-1:0]        valid,
    input  logic [NUM_UNITS*ADDR_W-1:0] addr_in,
    input  logic                        pending,
    output logic [ADDR_W-1:0]           addr_q
);
    logic [ADDR_W-1:0] pick;
    logic              any;

    // Pick the address of the lowest-numbered reporting unit.
    always_comb begin
        pick = '0;
        for (int i = NUM_UNITS - 1; i >= 0; i--) begin
            if (valid[i]) pick = addr_in[i*ADDR_W +: ADDR_W];
        end
        any = |valid;
    end

    // Capture register: loads only when no unmasked cause is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)              addr_q <= '0;
        else if (any && !pending) addr_q <= pick;
    end
endmodule

// File: rtl/err_cause_agg.sv
// Module: top of the error cause aggregator. It holds one cause group
// per subunit, a mask, a first-error address and a level interrupt.
// Assumes a register port with a combinational read and one-cycle
// write strobes, and ADDR_W no wider than the cause word.
module err_cause_agg
    import err_cause_pkg::*;
#(
    parameter int                 NUM_UNITS = 8,
    parameter int                 ADDR_W    = 32,
    parameter logic [NUM_UNITS-1:0] RSVD_MAP = 8'b0100_1000,
    localparam int                CAUSE_W   = NUM_UNITS * GROUP_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_UNITS-1:0]        err_pulse,
    input  logic [NUM_UNITS*KIND_W-1:0] err_kind,
    input  logic [NUM_UNITS*ADDR_W-1:0] err_addr,
    input  logic [1:0]                  reg_sel,
    input  logic                        reg_wr,
    input  logic [CAUSE_W-1:0]          reg_wdata,
    output logic [CAUSE_W-1:0]          reg_rdata,
    output logic                        irq
);
    // Implemented-bit map: kind bits of every non-reserved group.
    function automatic logic [CAUSE_W-1:0] impl_map();
        logic [CAUSE_W-1:0] m;
        m = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (!RSVD_MAP[u]) m[u*GROUP_W +: KIND_W] = '1;
        end
        return m;
    endfunction

    localparam logic [CAUSE_W-1:0] IMPL = impl_map();

    reg_sel_e               sel;
    logic [CAUSE_W-1:0]     cause_q;
    logic [CAUSE_W-1:0]     mask_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [NUM_UNITS-1:0]   evt_valid;
    logic                   cause_we;
    logic                   mask_we;
    logic                   pending;

    assign sel      = reg_sel_e'(reg_sel);
    assign cause_we = reg_wr && (sel == SEL_CAUSE);
    assign mask_we  = reg_wr && (sel == SEL_MASK);

    // One cause group per slot; reserved slots are tied to zero.
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        if (RSVD_MAP[u]) begin : g_rsvd
            assign cause_q[u*GROUP_W +: GROUP_W] = '0;
            assign evt_valid[u] = 1'b0;
        end else begin : g_live
            assign evt_valid[u] = err_pulse[u] && (|err_kind[u*KIND_W +: KIND_W]);
            err_cause_group u_grp (
                .clk       (clk),
                .rst_n     (rst_n),
                .evt       (err_pulse[u]),
                .kind      (err_kind[u*KIND_W +: KIND_W]),
                .clr_we    (cause_we),
                .keep_bits (reg_wdata[u*GROUP_W +: KIND_W]),
                .grp_q     (cause_q[u*GROUP_W +: GROUP_W])
            );
        end
    end

    err_mask_reg #(.W(CAUSE_W), .IMPL(IMPL)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mask_we),
        .wdata  (reg_wdata),
        .mask_q (mask_q)
    );

    // Outstanding unmasked cause, seen before the current edge.
    assign pending = |(cause_q & mask_q);

    err_addr_capture #(.NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (evt_valid),
        .addr_in (err_addr),
        .pending (pending),
        .addr_q  (addr_q)
    );

    // Level interrupt follows the outstanding unmasked causes.
    assign irq = pending;

    // Read mux over the three registers.
    always_comb begin
        unique case (sel)
            SEL_CAUSE: reg_rdata = cause_q;
            SEL_MASK:  reg_rdata = mask_q;
            SEL_ADDR:  reg_rdata = CAUSE_W'(addr_q);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/err_cause_agg_chk.sv
// Module: assertion checker bound to err_cause_agg. It observes the
// ports plus the cause, mask and captured-address state.
module err_cause_agg_chk #(
    parameter int NUM_UNITS = 8,
    parameter int ADDR_W    = 32,
    parameter int CAUSE_W   = NUM_UNITS * 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_UNITS-1:0]   err_pulse,
    input logic [NUM_UNITS*3-1:0] err_kind,
    input logic [1:0]             reg_sel,
    input logic                   reg_wr,
    input logic [CAUSE_W-1:0]     reg_wdata,
    input logic                   irq,
    input logic [CAUSE_W-1:0]     cause_q,
    input logic [CAUSE_W-1:0]     mask_q,
    input logic [ADDR_W-1:0]      addr_q
);
    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse[0] && err_kind[0]) |=> cause_q[0]);

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && !reg_wdata[4] && !(err_pulse[1] && err_kind[3]))
        |=> !cause_q[4]);

    // R3
    rsvd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse[3] |=> (cause_q[15:12] == 4'd0));

    // R7
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cause_q & mask_q)) |=> $stable(addr_q));

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|err_pulse) || $past(reg_wr && reg_sel == 2'd1)));
endmodule

bind err_cause_agg err_cause_agg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_pulse (err_pulse),
    .err_kind  (err_kind),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .cause_q   (cause_q),
    .mask_q    (mask_q),
    .addr_q    (addr_q)
);

// File: tb/err_cause_agg_tb.sv
module err_cause_agg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NU = 8;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NU-1:0]   err_pulse = '0;
    logic [NU*3-1:0] err_kind = '0;
    logic [NU*AW-1:0] err_addr;
    logic [1:0]      reg_sel = 2'd0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    err_cause_agg u_dut (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .err_kind(err_kind),
        .err_addr(err_addr), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic fire(input logic [NU-1:0] units, input logic [2:0] k);
        err_pulse = units;
        for (int u = 0; u < NU; u++) err_kind[u*3 +: 3] = units[u] ? k : 3'd0;
        @(negedge clk);
        err_pulse = '0; err_kind = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 cause", v, 32'h0);
        rd(2'd1, v); check("R1 mask", v, 32'h0);
        rd(2'd2, v); check("R1 addr", v, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        fire(8'h01, 3'b001);
        fire(8'h20, 3'b110);
        fire(8'h04, 3'b100);
        rd(2'd0, v); check("R2 group layout", v, 32'h0060_0401);
        check("R5 masked irq", {31'd0, irq}, 32'd0);
        rd(2'd2, v); check("R7 load when idle", v, 32'h3000);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        fire(8'h48, 3'b111);
        rd(2'd0, v); check("R3 cause", v, 32'h0060_0401);
        rd(2'd2, v); check("R3 addr", v, 32'h3000);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(2'd0, ~32'h1);
        rd(2'd0, v); check("R4 clear one", v, 32'h0060_0400);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R4 ones keep", v, 32'h0060_0400);
        wr(2'd0, 32'h0);
        rd(2'd0, v); check("R4 clear all", v, 32'h0);
    endtask

    task automatic t_mask_irq();
        logic [31:0] v;
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); check("R9 mask readback", v, 32'h7077_0777);
        check("R5 idle irq", {31'd0, irq}, 32'd0);
        fire(8'h80, 3'b010);
        check("R5 irq rise", {31'd0, irq}, 32'd1);
        rd(2'd2, v); check("R7 first addr", v, 32'h8000);
        fire(8'h02, 3'b001);
        rd(2'd2, v); check("R7 hold first", v, 32'h8000);
        rd(2'd0, v); check("R2 accumulate", v, 32'h2000_0010);
        wr(2'd0, ~32'h2000_0000);
        check("R5 irq stays", {31'd0, irq}, 32'd1);
        wr(2'd0, ~32'h10);
        check("R5 irq falls", {31'd0, irq}, 32'd0);
        wr(2'd1, 32'h2);
        fire(8'h01, 3'b001);
        check("R5 masked bit", {31'd0, irq}, 32'd0);
        rd(2'd2, v); check("R7 reload", v, 32'h1000);
        fire(8'h01, 3'b010);
        check("R5 unmasked bit", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(2'd1, 32'hFFFF_FFFF);
        fire(8'h10, 3'b001);
        reg_sel = 2'd0; reg_wdata = 32'h0; reg_wr = 1'b1;
        err_pulse = 8'h10; err_kind = '0; err_kind[12 +: 3] = 3'b100;
        @(negedge clk);
        reg_wr = 1'b0; err_pulse = '0; err_kind = '0;
        rd(2'd0, v); check("R6 set beats clear", v, 32'h0004_0000);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_simul();
        logic [31:0] v;
        fire(8'hA2, 3'b001);
        rd(2'd2, v); check("R8 lowest unit", v, 32'h2000);
        rd(2'd0, v); check("R8 cause", v, 32'h1010_0010);
        wr(2'd0, 32'h0);
        fire(8'h18, 3'b001);
        rd(2'd2, v); check("R8 skip reserved", v, 32'h5000);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_addr_ro();
        logic [31:0] v;
        wr(2'd2, 32'hDEAD_BEEF);
        rd(2'd2, v); check("R9 addr read-only", v, 32'h5000);
        rd(2'd3, v); check("R9 spare reads zero", v, 32'h0);
    endtask

    initial begin
        for (int u = 0; u < NU; u++) err_addr[u*AW +: AW] = 32'((u + 1) << 12);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_reserved();
        t_clear();
        t_mask_irq();
        t_collide();
        t_simul();
        t_addr_ro();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule